// File: doc/BRIEF.md
# Single-Source Clock Divider Tree

This block derives all board clocks from one fast oscillator clock so that the programmable logic has exactly one clock domain. From a 29.4912 MHz input it produces a 3.6864 MHz serial-controller clock (divide by 8), a CPU clock of about 9.83 MHz (divide by 3, shaped to 50% duty with a falling-edge stage), and a peripheral E clock of about 0.98 MHz. The E clock is the CPU clock divided by 10, with an asymmetric low-6 / high-4 pattern counted in CPU cycles.

Each derived clock has a single-cycle enable pulse in the fast domain that is high in the fast cycle where that clock rises. Logic running on the fast clock uses these pulses instead of the derived clocks. A synchronous active-high reset puts every divider at phase zero, so the three outputs always keep the same phase relation to one another.

Top module: `clk_tree_gen`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, every output is 0 from the following fast cycle onward. `cpu_clk` is 0 after the first falling edge of `clk` in reset.
- R2: Counting rising edges k = 1, 2, ... after reset release, `ser_clk` is 1 in fast cycle k exactly when (k mod 8) >= 4. This gives low 4 and high 4 fast cycles, period 8.
- R3: `ser_en` is 1 in fast cycle k exactly when k mod 8 = 4, which is the cycle in which `ser_clk` rises.
- R4: `cpu_clk` rises at every rising edge with k mod 3 = 0, and its period is 3 fast cycles.
- R5: `cpu_clk` is high for 1.5 fast cycles. It is high through fast cycle k with k mod 3 = 0 and through the first half of the next fast cycle. It is low otherwise.
- R6: `cpu_en` is 1 in fast cycle k exactly when k mod 3 = 0.
- R7: With m = floor(k/3) CPU rising edges since reset release, `e_clk` is 1 exactly when (m mod 10) >= 6. It is therefore low for 6 CPU cycles and high for 4, and changes only at CPU rising edges.
- R8: `e_en` is 1 in fast cycle k exactly when k mod 3 = 0 and (m mod 10) = 6, which is the cycle in which `e_clk` rises.
- R9: A reset applied mid-run restarts all three dividers together, so the R2 to R8 patterns start again from k = 1 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock, the only clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | output | 1 | Serial-controller clock, input / 8 |
| ser_en | output | 1 | Fast-domain pulse in the cycle `ser_clk` rises |
| cpu_clk | output | 1 | CPU clock, input / 3, 50% duty |
| cpu_en | output | 1 | Fast-domain pulse in the cycle `cpu_clk` rises |
| e_clk | output | 1 | Peripheral E clock, CPU clock / 10, low 6 / high 4 |
| e_en | output | 1 | Fast-domain pulse in the cycle `e_clk` rises |

## Verification
The assertions assume a free-running `clk` and a `rst` that stays stable across both clock edges, because the falling-edge shaping stage samples reset as well. The stimulus therefore changes `rst` only shortly after a falling edge, well clear of both edges. It holds reset for several cycles, both at start-up and when it is reapplied mid-run. The first reset cycle is left unchecked, because the falling-edge stage still holds its old value during that cycle.

// File: rtl/clk_tree_pkg.sv
package clk_tree_pkg;

  // Counter width able to hold 0 .. n-1, never less than one bit.
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/clkdiv_asym.sv
// Divider with programmable low/high split. The counter advances only on
// cycles where adv_i is high, so the same block serves as a direct
// divider of the fast clock or as a secondary divider fed by another
// divider's tick.
module clkdiv_asym #(
  parameter int DIV = 8,
  parameter int LOW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  output logic div_o,
  output logic en_o
);
  localparam int CW = clk_tree_pkg::cnt_width(DIV);
  localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
  localparam logic [CW-1:0] HI_AT = CW'(LOW);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (adv_i) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_o <= 1'b0;
      en_o  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      div_o <= (cnt_d >= HI_AT);
      en_o  <= adv_i && (cnt_d == HI_AT);
    end
  end
endmodule

// File: rtl/clkdiv_odd50.sv
// Odd-ratio divider with 50% duty: a rising-edge pulse of (DIV-1)/2
// cycles is ORed with a copy of itself delayed by half a fast cycle.
module clkdiv_odd50 #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst,
  output logic div_o,
  output logic en_o,
  output logic tick_o
);
  localparam int CW = clk_tree_pkg::cnt_width(DIV);
  localparam logic [CW-1:0] LAST   = CW'(DIV - 1);
  localparam logic [CW-1:0] HI_LEN = CW'((DIV - 1) / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          pos_q;
  logic          neg_q;

  always_comb cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

  // High in the fast cycle whose closing edge starts a new output period.
  assign tick_o = !rst && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pos_q <= 1'b0;
      en_o  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pos_q <= (cnt_d < HI_LEN);
      en_o  <= (cnt_d == '0);
    end
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      neg_q <= 1'b0;
    end else begin
      neg_q <= pos_q;
    end
  end

  assign div_o = pos_q | neg_q;
endmodule

// File: rtl/clk_tree_gen.sv
module clk_tree_gen #(
  parameter int SER_DIV = 8,
  parameter int CPU_DIV = 3,
  parameter int E_DIV   = 10,
  parameter int E_LOW   = 6
) (
  input  logic clk,
  input  logic rst,
  output logic ser_clk,
  output logic ser_en,
  output logic cpu_clk,
  output logic cpu_en,
  output logic e_clk,
  output logic e_en
);
  localparam int SER_LOW = SER_DIV / 2;

  logic cpu_tick;

  clkdiv_asym #(.DIV(SER_DIV), .LOW(SER_LOW)) u_ser (
    .clk   (clk),
    .rst   (rst),
    .adv_i (1'b1),
    .div_o (ser_clk),
    .en_o  (ser_en)
  );

  clkdiv_odd50 #(.DIV(CPU_DIV)) u_cpu (
    .clk    (clk),
    .rst    (rst),
    .div_o  (cpu_clk),
    .en_o   (cpu_en),
    .tick_o (cpu_tick)
  );

  clkdiv_asym #(.DIV(E_DIV), .LOW(E_LOW)) u_e (
    .clk   (clk),
    .rst   (rst),
    .adv_i (cpu_tick),
    .div_o (e_clk),
    .en_o  (e_en)
  );
endmodule

// File: rtl/clk_tree_chk.sv
module clk_tree_chk #(
  parameter int SER_DIV = 8,
  parameter int CPU_DIV = 3
) (
  input logic clk,
  input logic rst,
  input logic ser_clk,
  input logic ser_en,
  input logic cpu_clk,
  input logic cpu_en,
  input logic e_clk,
  input logic e_en
);
  logic [15:0] ser_gap;
  logic [15:0] cpu_gap;
  logic        ser_seen;
  logic        cpu_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_gap  <= '0;
      cpu_gap  <= '0;
      ser_seen <= 1'b0;
      cpu_seen <= 1'b0;
    end else begin
      ser_gap <= ser_en ? 16'd1 : ser_gap + 16'd1;
      cpu_gap <= cpu_en ? 16'd1 : cpu_gap + 16'd1;
      if (ser_en) ser_seen <= 1'b1;
      if (cpu_en) cpu_seen <= 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!ser_clk && !ser_en && !cpu_en && !e_clk && !e_en));

  assert_ser_period_R2: assert property (@(posedge clk) disable iff (rst)
    (ser_en && ser_seen) |-> (ser_gap == 16'(SER_DIV)));

  assert_ser_en_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    ser_en |-> $rose(ser_clk));

  assert_cpu_period_R4: assert property (@(posedge clk) disable iff (rst)
    (cpu_en && cpu_seen) |-> (cpu_gap == 16'(CPU_DIV)));

  assert_cpu_high_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_en |-> cpu_clk);

  assert_cpu_low_after_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_en |=> !cpu_clk);

  assert_e_moves_on_cpu_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(e_clk) || $fell(e_clk)) |-> cpu_en);

  assert_e_en_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
    e_en |-> ($rose(e_clk) && cpu_en));
endmodule

bind clk_tree_gen clk_tree_chk #(.SER_DIV(SER_DIV), .CPU_DIV(CPU_DIV)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .ser_clk (ser_clk),
  .ser_en  (ser_en),
  .cpu_clk (cpu_clk),
  .cpu_en  (cpu_en),
  .e_clk   (e_clk),
  .e_en    (e_en)
);

// File: tb/test_clk_tree_gen.sv
`timescale 1ns/100ps
module test_clk_tree_gen;
  typedef struct packed {
    logic chk;
    logic ser;
    logic ser_en;
    logic cpu_a;
    logic cpu_b;
    logic cpu_en;
    logic e;
    logic e_en;
    logic mid;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk, ser_en, cpu_clk, cpu_en, e_clk, e_en;

  int   n_vec  = 0;
  int   n_fail = 0;
  int   k      = 0;
  logic prev_r = 1'b0;
  logic after_mid = 1'b0;
  bit   done   = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  clk_tree_gen i_clk_tree_gen (
    .clk(clk), .rst(rst),
    .ser_clk(ser_clk), .ser_en(ser_en),
    .cpu_clk(cpu_clk), .cpu_en(cpu_en),
    .e_clk(e_clk), .e_en(e_en)
  );

  task automatic cmp(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s k=%0d actual=%b expected=%b", tag, k, act, exp);
    end
  endtask

  // Driver: one expected item per fast cycle, computed from the cycle index.
  task automatic phase(input logic r, input int n);
    rst = r;
    for (int i = 0; i < n; i++) begin
      exp_t it;
      int m;
      @(posedge clk);
      it = '0;
      if (r) begin
        k = 0;
        it.chk = prev_r;
      end else begin
        k++;
        m = k / 3;
        it.chk    = 1'b1;
        it.ser    = (k % 8) >= 4;
        it.ser_en = (k % 8) == 4;
        it.cpu_a  = ((k % 3) == 0) || (((k % 3) == 1) && (k >= 4));
        it.cpu_b  = (k % 3) == 0;
        it.cpu_en = (k % 3) == 0;
        it.e      = (m % 10) >= 6;
        it.e_en   = ((k % 3) == 0) && ((m % 10) == 6);
        it.mid    = after_mid;
      end
      prev_r = r;
      q.push_back(it);
    end
    #3;
  endtask

  // Monitor: compare first half after the rising edge, CPU clock again after the falling edge.
  initial begin
    forever begin
      exp_t it;
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.chk) begin
          if (!it.mid && rst) begin
            cmp("R1 ser_clk", ser_clk, 1'b0);
            cmp("R1 e_clk", e_clk, 1'b0);
            cmp("R1 enables", ser_en | cpu_en | e_en, 1'b0);
            cmp("R1 cpu_clk", cpu_clk, 1'b0);
          end else if (it.mid) begin
            cmp("R9 ser_clk restart", ser_clk, it.ser);
            cmp("R9 cpu_clk restart", cpu_clk, it.cpu_a);
            cmp("R9 e_clk restart", e_clk, it.e);
          end
          cmp("R2 ser_clk", ser_clk, it.ser);
          cmp("R3 ser_en", ser_en, it.ser_en);
          cmp("R4 cpu_clk first half", cpu_clk, it.cpu_a);
          cmp("R6 cpu_en", cpu_en, it.cpu_en);
          cmp("R7 e_clk", e_clk, it.e);
          cmp("R8 e_en", e_en, it.e_en);
          @(negedge clk);
          #1;
          cmp("R5 cpu_clk second half", cpu_clk, it.cpu_b);
        end
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      n_vec++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    phase(1'b1, 5);
    phase(1'b0, 250);
    phase(1'b1, 4);
    after_mid = 1'b1;
    phase(1'b0, 120);
    after_mid = 1'b0;
    phase(1'b1, 3);
    phase(1'b0, 400);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule